// File: doc/BRIEF.md
# Adaptive Power Mode Sequencer

This block decides how often a motion sensor samples its surface. It starts in a full-rate Run mode. After a stretch of time with no motion reported, it steps down through three Rest levels. Each Rest level samples more slowly than the one before, so the sensor draws less power.

Any motion reported in an automatically chosen mode sends the block straight back to Run. A two-bit field from a configuration register can also pin the block at any Rest level. When that field is cleared again, the block waits out a wake delay and then resumes Run.

All time is measured in ticks of an external timebase. Every sampling period, idle timeout and the wake delay is a tick-count parameter, so a bench can shrink them. The block drives a one-cycle frame-start strobe at the sampling period of the current mode, and reports the mode on a two-bit status output.

Top module: `pwr_mode_seq`

## Requirements
- R1: A synchronous reset puts the block in Run (status 00) with the idle timer cleared and `frame_start` low.
- R2: Status encodes Run = 00, Rest1 = 01, Rest2 = 10 and Rest3 = 11. With no motion, Run moves to Rest1 on the R1_IDLE-th tick, and Rest1 moves to Rest2 R2_IDLE ticks later. Rest2 moves to Rest3 R3_IDLE ticks after that. The idle timer restarts from zero at each step, and a step never skips a level.
- R3: Rest3 is the lowest level. Further ticks without motion leave the status at 11.
- R4: In automatic operation, `motion` high in a cycle returns the status to 00 in the next cycle and clears the idle timer. Motion wins over a tick in the same cycle.
- R5: `frame_start` is a one-cycle pulse that appears in the cycle after every N-th tick, where N is the sampling period of the current mode (RUN_PER, R1_PER, R2_PER, R3_PER). The period count restarts at every mode change. No pulse occurs without ticks.
- R6: When `force_rest` is nonzero (01 = Rest1, 10 = Rest2, 11 = Rest3), the status equals that value in the next cycle. The field can switch between levels at any time.
- R7: While `force_rest` is nonzero, motion and idle ticks leave the status unchanged.
- R8: When `force_rest` returns to 00, the status keeps its last forced level and motion is ignored for WAKE ticks. On the WAKE-th tick the status goes to 00 with a fresh idle timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| motion | input | 1 | Per-frame motion-detected strobe |
| force_rest | input | 2 | Forced-rest field: 00 automatic, else Rest level to hold |
| frame_start | output | 1 | One-cycle sampling strobe at the current mode's period |
| mode | output | 2 | Current mode status |

## Verification
The bench walks the idle chain across each threshold, stopping one tick short and one tick past. A timer that was not restarted at each step, or that let a step skip a level, shows up as a wrong status at these points.

It places motion together with a tick on the very tick that would otherwise cause a downshift. A design that gave the tick priority over motion would drop to Rest1 there.

It counts frame strobes over fixed tick windows in several modes. A wrong period mux, or a count that was not restarted, gives a wrong total.

The forced-rest tests send motion and long runs of idle ticks while a level is forced, and again during the wake delay. A design that leaked automatic behaviour into these windows would leave the forced level early or wake too soon.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_REST1 = 2'b01,
        MODE_REST2 = 2'b10,
        MODE_REST3 = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/pms_period_timer.sv
module pms_period_timer
    import pwr_mode_pkg::*;
#(
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned RUN_PER = 1,
    parameter int unsigned R1_PER  = 33,
    parameter int unsigned R2_PER  = 164,
    parameter int unsigned R3_PER  = 820
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      restart,
    input  pwr_mode_e cur_mode,
    output logic      frame_start
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic             frame;
    } tmr_t;

    tmr_t             s_d, s_q;
    logic [CNT_W-1:0] per_last;

    always_comb begin
        unique case (cur_mode)
            MODE_RUN:   per_last = CNT_W'(RUN_PER - 1);
            MODE_REST1: per_last = CNT_W'(R1_PER - 1);
            MODE_REST2: per_last = CNT_W'(R2_PER - 1);
            default:    per_last = CNT_W'(R3_PER - 1);
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.frame = 1'b0;
        if (restart) begin
            s_d.per = '0;
        end else if (tick) begin
            if (s_q.per >= per_last) begin
                s_d.per   = '0;
                s_d.frame = 1'b1;
            end else begin
                s_d.per = s_q.per + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign frame_start = s_q.frame;

    p_frame_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> $past(tick));
    p_no_frame_on_restart_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> !frame_start);
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int unsigned CNT_W   = 20,
    parameter int unsigned R1_IDLE = 474,
    parameter int unsigned R2_IDLE = 16800,
    parameter int unsigned R3_IDLE = 1008000,
    parameter int unsigned WAKE    = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       motion,
    input  logic [1:0] force_rest,
    output pwr_mode_e  cur_mode,
    output logic       mode_change
);
    typedef struct packed {
        pwr_mode_e        mode;
        logic [CNT_W-1:0] idle;
        logic [CNT_W-1:0] wake;
        logic             held;
    } fsm_t;

    fsm_t             s_d, s_q;
    logic [CNT_W-1:0] idle_last;

    always_comb begin
        unique case (s_q.mode)
            MODE_RUN:   idle_last = CNT_W'(R1_IDLE - 1);
            MODE_REST1: idle_last = CNT_W'(R2_IDLE - 1);
            default:    idle_last = CNT_W'(R3_IDLE - 1);
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (force_rest != 2'b00) begin
            s_d.mode = pwr_mode_e'(force_rest);
            s_d.held = 1'b1;
            s_d.idle = '0;
            s_d.wake = '0;
        end else if (s_q.held) begin
            if (tick) begin
                if (s_q.wake >= CNT_W'(WAKE - 1)) begin
                    s_d.mode = MODE_RUN;
                    s_d.held = 1'b0;
                    s_d.wake = '0;
                    s_d.idle = '0;
                end else begin
                    s_d.wake = s_q.wake + 1'b1;
                end
            end
        end else if (motion) begin
            s_d.mode = MODE_RUN;
            s_d.idle = '0;
        end else if (tick && s_q.mode != MODE_REST3) begin
            if (s_q.idle >= idle_last) begin
                s_d.mode = pwr_mode_e'(s_q.mode + 2'd1);
                s_d.idle = '0;
            end else begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{mode: MODE_RUN, idle: '0, wake: '0, held: 1'b0};
        else     s_q <= s_d;
    end

    assign cur_mode    = s_q.mode;
    assign mode_change = (s_d.mode != s_q.mode);

    p_motion_to_run_r4: assert property (@(posedge clk) disable iff (rst)
        (motion && force_rest == 2'b00 && !s_q.held) |=> (cur_mode == MODE_RUN));
    p_force_level_r6: assert property (@(posedge clk) disable iff (rst)
        (force_rest != 2'b00) |=> (cur_mode == pwr_mode_e'($past(force_rest))));
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (force_rest == 2'b00 && !s_q.held) |=>
        (cur_mode == MODE_RUN || cur_mode == $past(cur_mode)
         || cur_mode == pwr_mode_e'($past(cur_mode) + 2'd1)));
    p_wake_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (force_rest == 2'b00 && s_q.held && !tick) |=> $stable(cur_mode));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int unsigned RUN_PER = 1,
    parameter int unsigned R1_PER  = 33,
    parameter int unsigned R2_PER  = 164,
    parameter int unsigned R3_PER  = 820,
    parameter int unsigned R1_IDLE = 474,
    parameter int unsigned R2_IDLE = 16800,
    parameter int unsigned R3_IDLE = 1008000,
    parameter int unsigned WAKE    = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       motion,
    input  logic [1:0] force_rest,
    output logic       frame_start,
    output logic [1:0] mode
);
    localparam int unsigned MAX_PER  = (R3_PER > R2_PER ? R3_PER : R2_PER) > (R1_PER > RUN_PER ? R1_PER : RUN_PER)
                                     ? (R3_PER > R2_PER ? R3_PER : R2_PER) : (R1_PER > RUN_PER ? R1_PER : RUN_PER);
    localparam int unsigned MAX_IDL  = (R3_IDLE > R2_IDLE ? R3_IDLE : R2_IDLE) > (R1_IDLE > WAKE ? R1_IDLE : WAKE)
                                     ? (R3_IDLE > R2_IDLE ? R3_IDLE : R2_IDLE) : (R1_IDLE > WAKE ? R1_IDLE : WAKE);
    localparam int unsigned PER_W    = $clog2(MAX_PER + 1);
    localparam int unsigned IDL_W    = $clog2(MAX_IDL + 1);

    pwr_mode_e cur_mode;
    logic      mode_change;

    pms_mode_fsm #(
        .CNT_W   (IDL_W),
        .R1_IDLE (R1_IDLE),
        .R2_IDLE (R2_IDLE),
        .R3_IDLE (R3_IDLE),
        .WAKE    (WAKE)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .motion      (motion),
        .force_rest  (force_rest),
        .cur_mode    (cur_mode),
        .mode_change (mode_change)
    );

    pms_period_timer #(
        .CNT_W   (PER_W),
        .RUN_PER (RUN_PER),
        .R1_PER  (R1_PER),
        .R2_PER  (R2_PER),
        .R3_PER  (R3_PER)
    ) i_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .restart     (mode_change),
        .cur_mode    (cur_mode),
        .frame_start (frame_start)
    );

    assign mode = cur_mode;

    p_reset_run_r1: assert property (@(posedge clk)
        rst |=> (mode == 2'b00 && !frame_start));
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_PER = 2, R1_PER = 3, R2_PER = 4, R3_PER = 5;
    localparam int R1_IDLE = 6, R2_IDLE = 8, R3_IDLE = 10, WAKE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       motion = 1'b0;
    logic [1:0] force_rest = 2'b00;
    logic       frame_start;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int fcnt   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq #(
        .RUN_PER(RUN_PER), .R1_PER(R1_PER), .R2_PER(R2_PER), .R3_PER(R3_PER),
        .R1_IDLE(R1_IDLE), .R2_IDLE(R2_IDLE), .R3_IDLE(R3_IDLE), .WAKE(WAKE)
    ) i_pwr_mode_seq (
        .clk(clk), .rst(rst), .tick(tick), .motion(motion),
        .force_rest(force_rest), .frame_start(frame_start), .mode(mode)
    );

    always @(negedge clk) if (!rst && frame_start) fcnt++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick = 0; motion = 0; force_rest = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_motion(bit with_tick);
        @(negedge clk); motion = 1'b1; tick = with_tick;
        @(negedge clk); motion = 1'b0; tick = 1'b0;
    endtask

    task automatic set_force(logic [1:0] v);
        @(negedge clk); force_rest = v;
        @(negedge clk);
    endtask

    task automatic settle_frames();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 mode", mode, 0);
        check("R1 frame_start", frame_start, 0);
    endtask

    task automatic t_downshift();
        do_reset();
        ticks(R1_IDLE - 1);           check("R2 before rest1", mode, 0);
        ticks(1);                     check("R2 rest1", mode, 1);
        ticks(R2_IDLE - 1);           check("R2 before rest2", mode, 1);
        ticks(1);                     check("R2 rest2", mode, 2);
        ticks(R3_IDLE - 1);           check("R2 before rest3", mode, 2);
        ticks(1);                     check("R2 rest3", mode, 3);
        ticks(3 * R3_IDLE);           check("R3 floor", mode, 3);
    endtask

    task automatic t_motion();
        do_reset();
        ticks(R1_IDLE + R2_IDLE);     check("R4 setup rest2", mode, 2);
        pulse_motion(1'b0);           check("R4 motion to run", mode, 0);
        ticks(R1_IDLE - 1);           check("R4 idle cleared", mode, 0);
        ticks(1);                     check("R4 downshift after motion", mode, 1);
        ticks(3);
        pulse_motion(1'b1);           check("R4 motion from rest1 with tick", mode, 0);
        ticks(R1_IDLE - 1);
        pulse_motion(1'b1);           check("R4 motion beats threshold tick", mode, 0);
        ticks(R1_IDLE - 1);           check("R4 restart after tie", mode, 0);
        ticks(1);                     check("R4 rest1 after tie", mode, 1);
    endtask

    task automatic t_frames();
        do_reset();
        fcnt = 0; ticks(4); settle_frames();
        check("R5 run frames", fcnt, 4 / RUN_PER);
        set_force(2'b11);
        fcnt = 0; ticks(20); settle_frames();
        check("R5 rest3 frames", fcnt, 20 / R3_PER);
        set_force(2'b10);
        fcnt = 0; ticks(12); settle_frames();
        check("R5 rest2 frames", fcnt, 12 / R2_PER);
        set_force(2'b01);
        fcnt = 0; ticks(12); settle_frames();
        check("R5 rest1 frames", fcnt, 12 / R1_PER);
        fcnt = 0; repeat (8) @(negedge clk); #1;
        check("R5 no tick no frame", fcnt, 0);
    endtask

    task automatic t_force();
        do_reset();
        set_force(2'b10);             check("R6 force rest2", mode, 2);
        pulse_motion(1'b1);           check("R7 motion ignored", mode, 2);
        ticks(2 * R3_IDLE);           check("R7 idle ignored", mode, 2);
        set_force(2'b11);             check("R6 force rest3", mode, 3);
        set_force(2'b01);             check("R6 force rest1", mode, 1);
        set_force(2'b00);             check("R8 hold after release", mode, 1);
        pulse_motion(1'b0);           check("R8 motion ignored in wake", mode, 1);
        ticks(WAKE - 1);              check("R8 still waking", mode, 1);
        ticks(1);                     check("R8 run after wake", mode, 0);
        ticks(R1_IDLE - 1);           check("R8 fresh idle timer", mode, 0);
        ticks(1);                     check("R8 auto resumes", mode, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_downshift();
                t_motion();
                t_frames();
                t_force();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule